// File: doc/BRIEF.md
# Byte-Organised Load/Store Unit

This block carries out the memory half of load and store instructions for a 32-bit register machine. Each request names one of four transfers: word load, word store, byte load or byte store. It also supplies a 32-bit base value, a signed 16-bit displacement and 32-bit write data. The block adds base and displacement to form the effective address. It then touches one or four 8-bit cells of an internal byte array and answers one clock later with a response strobe, an error flag and 32 bits of load data.

Words are kept most-significant byte first. A word transfer gathers four neighbouring cells or spreads a register value across them. A byte load widens its cell to 32 bits by copying the sign bit. A byte store changes only the single cell it names. Word transfers must be aligned to 4 bytes. A misaligned word request writes nothing and is answered with the error flag set.

A small response controller has two named states. `ST_IDLE` means no response is being driven. `ST_RESP` means the result of the request accepted on the previous edge is on the outputs. The transitions are:
- `IDLE->RESP` and `RESP->RESP` on any cycle with `req_valid` high.
- `RESP->IDLE` and `IDLE->IDLE` when `req_valid` is low.
- Reset sends the controller to `ST_IDLE`.

Top module: `byte_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, taken modulo 2^32. Only its low log2(DEPTH) bits select the memory cell.
- R2: A word store (`req_op`=1) to an aligned address A writes bits 31:24 to cell A, 23:16 to A+1, 15:8 to A+2 and 7:0 to A+3.
- R3: A word load (`req_op`=0) from aligned address A returns {cell A, A+1, A+2, A+3} on `resp_rdata`, with cell A in bits 31:24.
- R4: A byte load (`req_op`=2) returns the addressed cell in bits 7:0, with bits 31:8 all copies of bit 7.
- R5: A byte store (`req_op`=3) writes `req_wdata[7:0]` into the addressed cell only. Every other cell keeps its contents.
- R6: A word request whose effective address has bits 1:0 not zero gets a response with `resp_err`=1 and `resp_rdata`=0, and changes no memory cell.
- R7: `resp_valid` is high in exactly those cycles that follow a cycle with `req_valid` high, so back-to-back requests each get a response in turn.
- R8: Synchronous active-high `rst` drives `resp_valid`, `resp_err` and `resp_rdata` to 0 on the next cycle and leaves memory contents unchanged.
- R9: Byte requests at any address, and aligned word requests, respond with `resp_err`=0. Store responses carry `resp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 word load, 1 word store, 2 byte load, 3 byte store |
| req_base | input | 32 | Base value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response strobe, one cycle after a request |
| resp_err | output | 1 | Misaligned word request |
| resp_rdata | output | 32 | Load data, zero for stores and errors |

## Verification
The bench first fills the whole array with word stores. It then reads every cell back both as words and as byte loads, with patterns that have the sign bit set and clear. A byte-order swap, a missed sign extension or a zero-extension would show up as wrong load data. Byte stores go to every cell, and the neighbouring words are read back afterwards. This exposes a byte store that writes a whole word, or the wrong lane. Misaligned word stores are followed by reads of the words around them, which catches a design that flags the error but still writes memory. Negative displacements, 32-bit address wrap and index wrap at the top of the array target address formation. Back-to-back requests and a reset raised during a request target a strobe that is late, stuck or not cleared.

// File: rtl/byte_lsu_pkg.sv
package byte_lsu_pkg;

    localparam int WORD_BYTES = 4;
    localparam int ADDR_W     = 32;
    localparam int DISP_W     = 16;

    typedef enum logic [1:0] {
        OP_LDW = 2'd0,
        OP_STW = 2'd1,
        OP_LDB = 2'd2,
        OP_STB = 2'd3
    } mem_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

    function automatic logic is_word_op(input mem_op_e op);
        return (op == OP_LDW) || (op == OP_STW);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import byte_lsu_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic              word_access,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [IDX_W-1:0]  cell_idx,
    output logic              misaligned
);
    localparam int ALIGN_W = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext   = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        eff_addr   = base + disp_ext;
        cell_idx   = eff_addr[IDX_W-1:0];
        misaligned = word_access && (eff_addr[ALIGN_W-1:0] != '0);
    end

endmodule

// File: rtl/lsu_bytemem.sv
module lsu_bytemem
    import byte_lsu_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [WORD_BYTES-1:0]   lane_we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WORD_BYTES*8-1:0] lane_wbytes,
    output logic [WORD_BYTES*8-1:0] lane_rbytes
);
    logic [7:0]       cells [DEPTH];
    logic [IDX_W-1:0] lane_idx [WORD_BYTES];

    genvar g;
    generate
        for (g = 0; g < WORD_BYTES; g++) begin : g_lane
            always_comb lane_idx[g] = idx + IDX_W'(g);
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (lane_we[i]) begin
                cells[lane_idx[i]] <= lane_wbytes[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            for (int i = 0; i < WORD_BYTES; i++) begin
                lane_rbytes[8*i +: 8] <= cells[lane_idx[i]];
            end
        end
    end

    // R2 R5: writes touch either nothing, the first lane only, or every lane
    lane_we_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_we == '0) || (lane_we == WORD_BYTES'(1)) || (lane_we == '1));

endmodule

// File: rtl/lsu_resp_fsm.sv
module lsu_resp_fsm
    import byte_lsu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  mem_op_e                 op_in,
    input  logic                    err_in,
    input  logic [WORD_BYTES*8-1:0] lane_rbytes,
    output logic                    resp_valid,
    output logic                    resp_err,
    output logic [31:0]             resp_rdata
);
    resp_state_e state_q, state_d;
    mem_op_e     op_q;
    logic        err_q;
    logic [31:0] word_be;
    logic [31:0] byte_sx;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LDW;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q  <= op_in;
                err_q <= err_in;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < WORD_BYTES; i++) begin
            word_be[8*(WORD_BYTES-1-i) +: 8] = lane_rbytes[8*i +: 8];
        end
        byte_sx = {{24{lane_rbytes[7]}}, lane_rbytes[7:0]};
    end

    always_comb begin
        resp_valid = 1'b0;
        resp_err   = 1'b0;
        resp_rdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                resp_valid = 1'b0;
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                resp_err   = err_q;
                if (!err_q) begin
                    unique case (op_q)
                        OP_LDW:  resp_rdata = word_be;
                        OP_LDB:  resp_rdata = byte_sx;
                        default: resp_rdata = '0;
                    endcase
                end
            end
            default: resp_valid = 1'b0;
        endcase
    end

    // R7
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> resp_valid);
    // R7
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !resp_valid);
    // R6
    err_has_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && resp_rdata == '0));
    // R4
    byte_sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_LDB) |=>
            ($countones(resp_rdata[31:7]) == 0 || $countones(resp_rdata[31:7]) == 25));
    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!resp_valid && !resp_err && resp_rdata == '0));

endmodule

// File: rtl/byte_lsu.sv
module byte_lsu
    import byte_lsu_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [31:0] req_base,
    input  logic [15:0] req_offset,
    input  logic [31:0] req_wdata,
    output logic        resp_valid,
    output logic        resp_err,
    output logic [31:0] resp_rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    mem_op_e                 op;
    logic [ADDR_W-1:0]       eff_addr;
    logic [IDX_W-1:0]        cell_idx;
    logic                    misaligned;
    logic                    accept;
    logic [WORD_BYTES-1:0]   lane_we;
    logic [WORD_BYTES*8-1:0] lane_wbytes;
    logic [WORD_BYTES*8-1:0] lane_rbytes;

    always_comb begin
        op     = mem_op_e'(req_op);
        accept = req_valid;
    end

    lsu_agen #(.IDX_W(IDX_W)) agen_i (
        .base        (req_base),
        .disp        (req_offset),
        .word_access (is_word_op(op)),
        .eff_addr    (eff_addr),
        .cell_idx    (cell_idx),
        .misaligned  (misaligned)
    );

    always_comb begin
        lane_we     = '0;
        lane_wbytes = '0;
        unique case (op)
            OP_STW: begin
                for (int i = 0; i < WORD_BYTES; i++) begin
                    lane_wbytes[8*i +: 8] = req_wdata[8*(WORD_BYTES-1-i) +: 8];
                end
                if (accept && !misaligned) lane_we = '1;
            end
            OP_STB: begin
                lane_wbytes[7:0] = req_wdata[7:0];
                if (accept) lane_we = WORD_BYTES'(1);
            end
            default: lane_we = '0;
        endcase
    end

    lsu_bytemem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) mem_i (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (accept),
        .lane_we     (lane_we),
        .idx         (cell_idx),
        .lane_wbytes (lane_wbytes),
        .lane_rbytes (lane_rbytes)
    );

    lsu_resp_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .op_in       (op),
        .err_in      (misaligned),
        .lane_rbytes (lane_rbytes),
        .resp_valid  (resp_valid),
        .resp_err    (resp_err),
        .resp_rdata  (resp_rdata)
    );

    // R6
    misalign_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && misaligned) |-> (lane_we == '0));
    // R9
    byte_never_err_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_word_op(op)) |=> !resp_err);

endmodule

// File: tb/byte_lsu_tb_top.sv
`timescale 1ns/1ps
module byte_lsu_tb_top;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic        resp_err;
    logic [31:0] resp_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    byte_lsu #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference for one request: computes expected response, updates model
    task automatic expect_of(input logic [1:0] op, input logic [31:0] base, input logic [15:0] off,
                             input logic [31:0] wd, output logic [31:0] erd, output logic eerr);
        logic [31:0] ea;
        logic [5:0]  ix;
        bit          word;
        ea   = base + {{16{off[15]}}, off};
        ix   = ea[5:0];
        word = (op == 2'd0) || (op == 2'd1);
        eerr = word && (ea[1:0] != 2'b00);
        erd  = '0;
        if (!eerr) begin
            case (op)
                2'd0: erd = {model[ix], model[6'(ix+1)], model[6'(ix+2)], model[6'(ix+3)]};
                2'd1: for (int k = 0; k < 4; k++) model[6'(ix+k)] = wd[8*(3-k) +: 8];
                2'd2: erd = {{24{model[ix][7]}}, model[ix]};
                default: model[ix] = wd[7:0];
            endcase
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] base, input logic [15:0] off,
                       input logic [31:0] wd, input string tag);
        logic [31:0] erd;
        logic        eerr;
        expect_of(op, base, off, wd, erd, eerr);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b1, "R7 strobe", {31'd0, resp_valid}, 32'd1);
        chk(resp_err === eerr, {tag, " err (R6/R9)"}, {31'd0, resp_err}, {31'd0, eerr});
        chk(resp_rdata === erd, {tag, " data"}, resp_rdata, erd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(resp_valid === 1'b0 && resp_err === 1'b0 && resp_rdata === 32'd0,
            "R8 reset outputs", resp_rdata, 32'd0);
        rst = 1'b0;

        // R2 fill all cells with word stores (sign bits varied)
        for (int a = 0; a < DEPTH; a += 4)
            run(2'd1, 32'(a), 16'd0, {8'(a*7+3), 8'(8'h80 | a), 8'(a), 8'(255-a)}, "R2 word store");
        // R3 read every word back
        for (int a = 0; a < DEPTH; a += 4)
            run(2'd0, 32'd0, 16'(a), 32'd0, "R3 word load");
        // R4 byte loads of every cell
        for (int a = 0; a < DEPTH; a++)
            run(2'd2, 32'(a), 16'd0, 32'd0, "R4 byte load");
        // R7 idle cycle gives no strobe
        @(negedge clk);
        chk(resp_valid === 1'b0, "R7 idle no strobe", {31'd0, resp_valid}, 32'd0);

        // R5 byte store to every cell, then words read back to check neighbours
        for (int a = 0; a < DEPTH; a++)
            run(2'd3, 32'd1000, 16'(a - 1000), {24'hFFFFFF, 8'(a ^ 8'hA5)}, "R5 byte store");
        for (int a = 0; a < DEPTH; a += 4)
            run(2'd0, 32'(a), 16'd0, 32'd0, "R5 neighbours");
        run(2'd3, 32'd9, 16'd0, 32'h1234_567E, "R5 single");
        for (int a = 4; a < 16; a += 4)
            run(2'd0, 32'(a), 16'd0, 32'd0, "R5 after single");

        // R6 misaligned word stores and loads
        for (int m = 1; m < 4; m++) begin
            run(2'd1, 32'(16 + m), 16'd0, 32'hDEAD_BEEF, "R6 misaligned store");
            run(2'd0, 32'(16 + m), 16'd0, 32'd0, "R6 misaligned load");
        end
        run(2'd0, 32'd16, 16'd0, 32'd0, "R6 unchanged lo");
        run(2'd0, 32'd20, 16'd0, 32'd0, "R6 unchanged hi");
        // R9 byte ops at odd addresses never error
        run(2'd2, 32'd17, 16'd0, 32'd0, "R9 odd byte load");
        run(2'd3, 32'd19, 16'd0, 32'h0000_0011, "R9 odd byte store");

        // R1 negative offset, 32-bit wrap, index wrap, array element offsets
        run(2'd1, 32'd100, 16'hFFDC, 32'h0102_0304, "R1 negative offset");
        run(2'd0, 32'd0, 16'd0, 32'd0, "R1 negative offset readback");
        run(2'd1, 32'hFFFF_FFF0, 16'h0014, 32'hCAFE_F00D, "R1 32-bit wrap");
        run(2'd0, 32'd4, 16'd0, 32'd0, "R1 32-bit wrap readback");
        run(2'd0, 32'h0000_1000 + 32'd8, 16'd0, 32'd0, "R1 index wrap");
        run(2'd0, 32'd0, 16'd32, 32'd0, "R1 element 8");
        run(2'd1, 32'd0, 16'd48, 32'h8000_0001, "R1 element 12 store");
        run(2'd2, 32'd0, 16'd48, 32'd0, "R1 element 12 msb byte");
        run(2'd2, 32'd0, 16'd51, 32'd0, "R1 element 12 lsb byte");

        // R7 back-to-back: byte store, byte store, word load
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_base = 32'd40; req_offset = 16'd0; req_wdata = 32'h77;
        model[40] = 8'h77;
        @(negedge clk);
        chk(resp_valid === 1'b1, "R7 back-to-back 1", {31'd0, resp_valid}, 32'd1);
        req_op = 2'd3; req_base = 32'd43; req_wdata = 32'h9C;
        model[43] = 8'h9C;
        @(negedge clk);
        chk(resp_valid === 1'b1, "R7 back-to-back 2", {31'd0, resp_valid}, 32'd1);
        req_op = 2'd0; req_base = 32'd40;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b1 && resp_rdata === {model[40], model[41], model[42], model[43]},
            "R7 back-to-back load", resp_rdata, {model[40], model[41], model[42], model[43]});
        @(negedge clk);
        chk(resp_valid === 1'b0, "R7 strobe drops", {31'd0, resp_valid}, 32'd0);

        // R8 reset during a request clears outputs, memory kept
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_base = 32'd40; rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b0;
        chk(resp_valid === 1'b0 && resp_err === 1'b0 && resp_rdata === 32'd0,
            "R8 reset mid-request", resp_rdata, 32'd0);
        for (int a = 0; a < DEPTH; a += 4)
            run(2'd0, 32'(a), 16'd0, 32'd0, "R8 memory kept");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule